// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers sixteen peripheral interrupt request lines and presents them, one at a time, on a single interrupt output toward the CPU. Inside it, two identical eight-input fixed-priority units are chained. The second unit serves lines 8 to 15, and its request output takes the place of input 2 of the first unit. The CPU acknowledges an interrupt with a one-cycle strobe. The block answers one cycle later with a one-byte interrupt number and the 10-bit byte address of that number's four-byte slot in the vector table.

Each unit holds an 8-bit pending register, an 8-bit in-service register and an 8-bit mask register. Request lines are passed through two synchroniser flip-flops and latched on a rising edge. A pending line is forwarded only when no line of equal or higher priority is in service. An end-of-interrupt strobe retires the highest-priority in-service line. A CPU-side enable gates the output so that delivery can be held back. Mask and vector-base registers are loaded through simple write strobes.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, int_o and vec_valid_o are 0, every mask bit is clear, and the vector bases are 0x08 for lines 0-7 and 0x70 for lines 8-15.
- R2: A rising edge on a request line becomes a pending request within three clock edges. The request stays pending after the line falls.
- R3: Among pending, unmasked lines, the winner follows the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7, from highest priority to lowest.
- R4: A pending line is not forwarded while a line of equal or higher priority is in service. A strictly higher-priority line is forwarded, so interrupts can nest.
- R5: An acknowledge strobe (inta_i high while int_o is high) moves the winner from pending to in-service. On the next cycle, vec_valid_o pulses and vec_num_o equals the unit's base with the 3-bit line index appended. The unit is the first one for lines 0-7 and the second one for lines 8-15.
- R6: On every cycle where vec_valid_o is high, vec_addr_o equals vec_num_o multiplied by 4, as a 10-bit value.
- R7: A mask bit of 1 lets its line latch a request but stops it from winning. When the bit is cleared, the latched request is delivered. Bit n of the mask data masks line index n of the selected unit.
- R8: While cpu_int_en_i is 0, int_o stays 0 and pending requests are kept. They are delivered once the enable returns to 1.
- R9: An end-of-interrupt strobe clears the highest-priority in-service bit of the first unit. When that bit is the cascade input 2, the strobe also clears the highest-priority in-service bit of the second unit.
- R10: Request line 2 is ignored and never causes int_o to rise.
- R11: base_we_i[0] loads the first unit's 5-bit base, and base_we_i[1] loads the second unit's base, each from cfg_data_i[4:0]. mask_we_i[0] and mask_we_i[1] load the 8-bit masks of the same two units from cfg_data_i.
- R12: An acknowledge strobe while int_o is 0 is ignored: vec_valid_o stays 0.
- R13: A new rising edge on a line that is already in service is latched as pending. It is delivered after that line's end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 16 | Peripheral request lines, asynchronous, rising-edge |
| cpu_int_en_i | input | 1 | CPU-side global interrupt enable |
| inta_i | input | 1 | Acknowledge strobe from the CPU |
| eoi_i | input | 1 | End-of-interrupt strobe |
| mask_we_i | input | 2 | Mask write strobes: bit 0 first unit, bit 1 second unit |
| base_we_i | input | 2 | Vector-base write strobes: bit 0 first unit, bit 1 second unit |
| cfg_data_i | input | 8 | Write data for mask and base |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | One-cycle pulse marking a valid vector |
| vec_num_o | output | 8 | Interrupt number |
| vec_addr_o | output | 10 | Byte address of the vector-table entry |

## Verification
The bench builds the block with its default parameters: two units of eight lines each, cascade on input 2, and bases 0x08 and 0x70. These defaults make every priority boundary reachable. That includes the case where a second-unit line overtakes first-unit lines 3-7, the check that the cascade's in-service bit holds back every second-unit line, and the combined end-of-interrupt across both units. With the bases reprogrammed, a high second-unit number such as 0x87 drives the vector address toward the upper end of the 10-bit range.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int CTRL_LINES = 8;
  localparam int NUM_CTRL   = 2;
  localparam int TOT_LINES  = CTRL_LINES * NUM_CTRL;
  localparam int IDX_W      = $clog2(CTRL_LINES);
  localparam int BASE_W     = 8 - IDX_W;
  localparam int VEC_W      = BASE_W + IDX_W;
  localparam int ENTRY_SH   = 2;
  localparam int ADDR_W     = VEC_W + ENTRY_SH;
  localparam int CASC_LINE  = 2;

  typedef struct packed {
    logic             any;
    logic [IDX_W-1:0] idx;
  } prio_pick_t;

  // lowest index set wins
  function automatic prio_pick_t pick_lowest(input logic [CTRL_LINES-1:0] v);
    prio_pick_t p;
    p = '0;
    for (int i = CTRL_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.any = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lines_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= lines_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_cascade_pkg::*;
#(
  parameter bit                CASC_EN  = 1'b0,
  parameter int                CASC_IDX = CASC_LINE,
  parameter logic [BASE_W-1:0] BASE_RST = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CTRL_LINES-1:0] rise_i,
  input  logic                  casc_req_i,
  input  logic                  mask_we_i,
  input  logic                  base_we_i,
  input  logic [7:0]            cfg_data_i,
  input  logic                  ack_i,
  input  logic                  eoi_i,
  output logic                  req_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [BASE_W-1:0]     base_o,
  output logic [IDX_W-1:0]      isr_top_o
);
  logic [CTRL_LINES-1:0] irr_q, isr_q, imr_q;
  logic [CTRL_LINES-1:0] req_vec;
  logic [BASE_W-1:0]     base_q;
  prio_pick_t            win, top;

  generate
    if (CASC_EN) begin : g_casc
      always_comb begin
        req_vec           = irr_q;
        req_vec[CASC_IDX] = casc_req_i;
      end
    end else begin : g_plain
      logic unused_casc;
      assign unused_casc = casc_req_i;
      assign req_vec     = irr_q;
    end
  endgenerate

  always_comb begin
    win = pick_lowest(req_vec & ~imr_q);
    top = pick_lowest(isr_q);
  end

  // forward only above every in-service level
  assign req_o     = win.any && (!top.any || (win.idx < top.idx));
  assign win_idx_o = win.idx;
  assign isr_top_o = top.idx;
  assign base_o    = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      base_q <= BASE_RST;
    end else begin
      for (int i = 0; i < CTRL_LINES; i++) begin
        if (rise_i[i]) irr_q[i] <= 1'b1;
        else if (ack_i && (win.idx == IDX_W'(i))) irr_q[i] <= 1'b0;
        if (ack_i && (win.idx == IDX_W'(i))) isr_q[i] <= 1'b1;
        else if (eoi_i && top.any && (top.idx == IDX_W'(i))) isr_q[i] <= 1'b0;
      end
      if (mask_we_i) imr_q  <= cfg_data_i;
      if (base_we_i) base_q <= cfg_data_i[BASE_W-1:0];
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter logic [BASE_W-1:0] MST_BASE_RST = 5'h01,
  parameter logic [BASE_W-1:0] SLV_BASE_RST = 5'h0E
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TOT_LINES-1:0] irq_lines_i,
  input  logic                 cpu_int_en_i,
  input  logic                 inta_i,
  input  logic                 eoi_i,
  input  logic [NUM_CTRL-1:0]  mask_we_i,
  input  logic [NUM_CTRL-1:0]  base_we_i,
  input  logic [7:0]           cfg_data_i,
  output logic                 int_o,
  output logic                 vec_valid_o,
  output logic [VEC_W-1:0]     vec_num_o,
  output logic [ADDR_W-1:0]    vec_addr_o
);
  logic [TOT_LINES-1:0]  rise;
  logic [CTRL_LINES-1:0] mst_rise;
  logic                  line2_unused;
  logic                  mst_req, slv_req, ack, mst_ack, slv_ack, slv_eoi;
  logic [IDX_W-1:0]      mst_win, slv_win, mst_top, slv_top_unused;
  logic [BASE_W-1:0]     mst_base, slv_base;
  logic [VEC_W-1:0]      num_d;
  logic                  via_slave;
  logic                  valid_q;
  logic [VEC_W-1:0]      num_q;
  logic [ADDR_W-1:0]     addr_q;

  irq_edge_sync #(.WIDTH(TOT_LINES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (irq_lines_i),
    .rise_o  (rise)
  );

  // cascade input replaces line 2
  always_comb begin
    mst_rise            = rise[CTRL_LINES-1:0];
    mst_rise[CASC_LINE] = 1'b0;
  end
  assign line2_unused = rise[CASC_LINE];

  assign int_o     = cpu_int_en_i && mst_req;
  assign ack       = inta_i && int_o;
  assign via_slave = (mst_win == IDX_W'(CASC_LINE));
  assign mst_ack   = ack;
  assign slv_ack   = ack && via_slave;
  assign slv_eoi   = eoi_i && (mst_top == IDX_W'(CASC_LINE));

  irq_prio_unit #(
    .CASC_EN  (1'b1),
    .CASC_IDX (CASC_LINE),
    .BASE_RST (MST_BASE_RST)
  ) i_mst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (mst_rise),
    .casc_req_i (slv_req),
    .mask_we_i  (mask_we_i[0]),
    .base_we_i  (base_we_i[0]),
    .cfg_data_i (cfg_data_i),
    .ack_i      (mst_ack),
    .eoi_i      (eoi_i),
    .req_o      (mst_req),
    .win_idx_o  (mst_win),
    .base_o     (mst_base),
    .isr_top_o  (mst_top)
  );

  irq_prio_unit #(
    .CASC_EN  (1'b0),
    .CASC_IDX (CASC_LINE),
    .BASE_RST (SLV_BASE_RST)
  ) i_slv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise[TOT_LINES-1:CTRL_LINES]),
    .casc_req_i (1'b0),
    .mask_we_i  (mask_we_i[1]),
    .base_we_i  (base_we_i[1]),
    .cfg_data_i (cfg_data_i),
    .ack_i      (slv_ack),
    .eoi_i      (slv_eoi),
    .req_o      (slv_req),
    .win_idx_o  (slv_win),
    .base_o     (slv_base),
    .isr_top_o  (slv_top_unused)
  );

  assign num_d = via_slave ? {slv_base, slv_win} : {mst_base, mst_win};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      num_q   <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= ack;
      if (ack) begin
        num_q  <= num_d;
        addr_q <= {num_d, {ENTRY_SH{1'b0}}};
      end
    end
  end

  assign vec_valid_o = valid_q;
  assign vec_num_o   = num_q;
  assign vec_addr_o  = addr_q;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_int_en_i,
  input logic              inta_i,
  input logic              int_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_num_o,
  input logic [ADDR_W-1:0] vec_addr_o
);
  // R5
  ack_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o) |=> vec_valid_o);
  // R12
  no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(inta_i && int_o));
  // R6
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_addr_o == {vec_num_o, 2'b00}));
  // R8
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_int_en_i |-> !int_o);
endmodule

bind irq_cascade_ctrl irq_cascade_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_int_en_i (cpu_int_en_i),
  .inta_i       (inta_i),
  .int_o        (int_o),
  .vec_valid_o  (vec_valid_o),
  .vec_num_o    (vec_num_o),
  .vec_addr_o   (vec_addr_o)
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lines = '0;
  logic        en = 1'b1;
  logic        inta = 1'b0;
  logic        eoi = 1'b0;
  logic [1:0]  mask_we = '0;
  logic [1:0]  base_we = '0;
  logic [7:0]  cfg = '0;
  logic        int_o, vvalid;
  logic [7:0]  vnum;
  logic [9:0]  vaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .irq_lines_i  (lines),
    .cpu_int_en_i (en),
    .inta_i       (inta),
    .eoi_i        (eoi),
    .mask_we_i    (mask_we),
    .base_we_i    (base_we),
    .cfg_data_i   (cfg),
    .int_o        (int_o),
    .vec_valid_o  (vvalid),
    .vec_num_o    (vnum),
    .vec_addr_o   (vaddr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected vectors as the design produces them
  always @(negedge clk) begin
    if (rst_n && vvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected vector", vnum, 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vnum == e, t, vnum, e);
        check(vaddr == 10'(e) * 10'd4, "R6 vector address", vaddr, 10'(e) * 10'd4);
      end
    end
  end

  task automatic raise(input logic [15:0] m);
    @(negedge clk) lines = lines | m;
    repeat (3) @(negedge clk);
    lines = lines & ~m;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] e, input string req);
    @(negedge clk);
    check(int_o == 1'b1, {req, " int_o before ack"}, int_o, 1);
    exp_q.push_back(e);
    tag_q.push_back(req);
    inta = 1'b1;
    @(negedge clk) inta = 1'b0;
  endtask

  task automatic end_int;
    @(negedge clk) eoi = 1'b1;
    @(negedge clk) eoi = 1'b0;
  endtask

  task automatic expect_int(input bit v, input string req);
    @(negedge clk);
    check(int_o == v, req, int_o, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(int_o == 1'b0, "R1 int_o", int_o, 0);
    check(vvalid == 1'b0, "R1 vec_valid", vvalid, 0);

    // R2, R5: single line, request held after line falls
    raise(16'h0020);
    expect_int(1'b1, "R2 pending after line fell");
    ack(8'h0D, "R5 line 5 default base");
    expect_int(1'b0, "R5 int_o drops after ack");
    end_int();

    // R3: lines 1, 3, 12 together -> 1, 12, 3
    raise(16'h100A);
    ack(8'h09, "R3 line 1 first");
    expect_int(1'b0, "R4 lower lines held behind line 1");
    end_int();
    ack(8'h74, "R3 line 12 before line 3");
    expect_int(1'b0, "R4 line 3 held behind cascade");
    end_int();
    ack(8'h0B, "R3 line 3 last");
    end_int();
    expect_int(1'b0, "R9 all retired");

    // R3: two slave lines, R9 combined EOI
    raise(16'h0300);
    ack(8'h70, "R3 line 8 before 9");
    expect_int(1'b0, "R4 line 9 held behind line 8");
    end_int();
    ack(8'h71, "R9 line 9 after combined EOI");
    end_int();

    // R4: nesting
    raise(16'h0040);
    ack(8'h0E, "R4 line 6");
    raise(16'h0001);
    expect_int(1'b1, "R4 higher line nests");
    ack(8'h08, "R4 nested line 0");
    end_int();
    expect_int(1'b0, "R9 EOI cleared line 0 only");
    end_int();

    // R13: retrigger while in service
    raise(16'h0020);
    ack(8'h0D, "R13 first line 5");
    raise(16'h0020);
    expect_int(1'b0, "R13 retrigger held while in service");
    end_int();
    expect_int(1'b1, "R13 retrigger pending after EOI");
    ack(8'h0D, "R13 second line 5");
    end_int();

    // R7, R11: mask line 4 on first unit
    @(negedge clk) begin cfg = 8'h10; mask_we = 2'b01; end
    @(negedge clk) mask_we = 2'b00;
    raise(16'h0010);
    expect_int(1'b0, "R7 masked line blocked");
    @(negedge clk) begin cfg = 8'h00; mask_we = 2'b01; end
    @(negedge clk) mask_we = 2'b00;
    expect_int(1'b1, "R7 unmasked line delivered");
    ack(8'h0C, "R7 line 4");
    end_int();

    // R8: global enable
    @(negedge clk) en = 1'b0;
    raise(16'h0080);
    expect_int(1'b0, "R8 enable low");
    @(negedge clk) en = 1'b1;
    ack(8'h0F, "R8 line 7 after enable");
    end_int();

    // R10: line 2 ignored
    raise(16'h0004);
    repeat (3) expect_int(1'b0, "R10 line 2 ignored");

    // R12: acknowledge with no request
    @(negedge clk) inta = 1'b1;
    @(negedge clk) inta = 1'b0;
    @(negedge clk);
    check(vvalid == 1'b0, "R12 spurious ack", vvalid, 0);

    // R11: reprogram second unit base to 0x10 (vector 0x80)
    @(negedge clk) begin cfg = 8'h10; base_we = 2'b10; end
    @(negedge clk) base_we = 2'b00;
    raise(16'h8000);
    ack(8'h87, "R11 line 15 new base");
    end_int();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all vectors delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule